// File: doc/BRIEF.md
# Execute-Stage Redirect Priority Arbiter

This block sits at the end of an out-of-order execute stage. Each cycle it receives a group of executed instructions in lanes, lane 0 holding the oldest. It also receives three per-thread event flags from the memory pipeline. For every hardware thread it raises at most one squash-and-redirect request toward the retirement stage.

The request is raised by the first lane of that thread that reports a cause. That lane takes a per-thread lock, and later lanes of the same thread in the same cycle are disregarded. The lock is released at the start of every cycle.

An instruction can report one of three causes. The first, and highest in priority, is a branch mispredict. The second is a memory-ordering violation reported for the thread. The third, and lowest, is a load that found the memory system blocked and whose event has not yet been handled. Each cause builds the outgoing record differently:

- A branch restarts fetch at the instruction's successor PC and excludes the instruction from the squash. It also reports the faulting PC and the direction it actually took.
- A memory-ordering violation restarts at the successor PC and excludes the instruction from the squash.
- A blocked load restarts at the load's own PC and includes the load in the squash. It also raises a pulse that tells the memory pipeline to mark the event as handled, so the event fires only once.

Two running counters per thread record mispredicts, one for mispredicts that were predicted taken and one for those predicted not taken.

Top module: `redirect_arbiter`

## Requirements
- R1: After reset every `rd_valid` and `ld_mark` bit is 0 and every mispredict counter reads 0.
- R2: For each thread, at most one request is produced per cycle. It comes from the lowest-index lane of that thread whose instruction reports a cause. Later lanes of that thread in the same cycle have no effect.
- R3: For one instruction, the cause is chosen in this order: its own mispredict bit, then the thread's memory-order violation flag, then the thread's blocked-load flag with its handled bit clear.
- R4: A branch request carries the instruction's sequence number, `rd_target` = its next PC, `rd_bad_pc` = its PC, `rd_mispred` = 1 and `rd_incl` = 0.
- R5: On a branch request, `rd_taken` is 1 exactly when next PC differs from PC + 4 (PCs are 32 bits, instructions are 4 bytes).
- R6: A memory-order request carries the sequence number, `rd_target` = next PC, `rd_incl` = 0, `rd_mispred` = 0, `rd_taken` = 0 and `rd_bad_pc` = 0.
- R7: A blocked-load request carries the sequence number, `rd_target` = the instruction's own PC, `rd_incl` = 1, `rd_mispred` = 0, `rd_taken` = 0, `rd_bad_pc` = 0, and raises `ld_mark` for that thread in the same cycle. While `ld_handled` is 1, a blocked load raises nothing.
- R8: A lane whose valid bit is 0 or whose squashed bit is 1 cannot raise a request. A lane only ever affects the thread named by its thread id.
- R9: Each branch request adds one to `cnt_pt_wrong` when the lane's predicted-taken bit was 1, and otherwise adds one to `cnt_pnt_wrong`. Other requests leave both counters unchanged.
- R10: A request is registered. `rd_valid` is 1 in exactly the one cycle after the triggering inputs and returns to 0 if no new trigger arrives.
- R11: The threads are arbitrated independently, and several threads may each receive a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | LANES | Lane holds an executed instruction |
| ex_squashed | input | LANES | Lane instruction already squashed |
| ex_mispred | input | LANES | Lane instruction is a mispredicted branch |
| ex_pred_taken | input | LANES | Predicted direction of the lane branch |
| ex_tid | input | LANES x TID_W | Thread of the lane instruction |
| ex_seq | input | LANES x SEQ_W | Sequence number of the lane instruction |
| ex_pc | input | LANES x PC_W | PC of the lane instruction |
| ex_npc | input | LANES x PC_W | Resolved next PC of the lane instruction |
| mo_viol | input | NT | Memory-ordering violation pending, per thread |
| ld_blocked | input | NT | Load blocked by memory, per thread |
| ld_handled | input | NT | Blocked-load event already handled, per thread |
| rd_valid | output | NT | Redirect request valid |
| rd_mispred | output | NT | Request caused by a branch mispredict |
| rd_taken | output | NT | Actual direction of the mispredicted branch |
| rd_incl | output | NT | Squash includes the triggering instruction |
| ld_mark | output | NT | Mark the blocked-load event handled |
| rd_seq | output | NT x SEQ_W | Sequence number of the triggering instruction |
| rd_target | output | NT x PC_W | Restart PC |
| rd_bad_pc | output | NT x PC_W | PC of the mispredicted branch |
| cnt_pt_wrong | output | NT x CNT_W | Mispredicts that were predicted taken |
| cnt_pnt_wrong | output | NT x CNT_W | Mispredicts that were predicted not taken |

## Verification
Every result depends on a single register stage. The request record, the `ld_mark` pulse and both counters all change at the first rising edge after the lane inputs are applied. The bench applies each group of inputs on a falling edge and compares all outputs on the next falling edge, which falls half a period after the capturing edge. New inputs follow only after that comparison. The bench's model of the handled bit takes its value from the expected `ld_mark` of the previous step, so the fires-once behaviour is checked over consecutive cycles.

// File: rtl/redir_pkg.sv
package redir_pkg;

  // Redirect cause, listed from no cause to lowest priority
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BRANCH = 2'd1,
    CAUSE_MEMORD = 2'd2,
    CAUSE_LDBLK  = 2'd3
  } cause_e;

  // Fixed priority for one instruction: own mispredict, then ordering
  // violation, then an unhandled blocked load.
  function automatic cause_e pick_cause(input logic mispred,
                                        input logic viol,
                                        input logic blk_open);
    if (mispred)       return CAUSE_BRANCH;
    else if (viol)     return CAUSE_MEMORD;
    else if (blk_open) return CAUSE_LDBLK;
    else               return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/redir_lane_eval.sv
module redir_lane_eval
  import redir_pkg::*;
#(
  parameter int NT         = 2,
  parameter int TID_W      = 1,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input  logic             valid_i,
  input  logic             squashed_i,
  input  logic             mispred_i,
  input  logic [TID_W-1:0] tid_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  npc_i,
  input  logic [NT-1:0]    viol_i,
  input  logic [NT-1:0]    blk_i,
  input  logic [NT-1:0]    hnd_i,
  output cause_e           cause_o [NT],
  output logic             taken_o
);

  // Branch went taken when its successor is not the sequential PC
  function automatic logic went_taken(input logic [PC_W-1:0] pc,
                                      input logic [PC_W-1:0] npc);
    return npc != (pc + PC_W'(INST_BYTES));
  endfunction

  logic live;
  assign live    = valid_i && !squashed_i;
  assign taken_o = went_taken(pc_i, npc_i);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic mine;
    assign mine = live && (tid_i == TID_W'(t));
    assign cause_o[t] = mine ? pick_cause(mispred_i, viol_i[t],
                                          blk_i[t] && !hnd_i[t])
                             : CAUSE_NONE;
  end

endmodule

// File: rtl/redir_thread_pick.sv
module redir_thread_pick
  import redir_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32
) (
  input  cause_e                        cause_i [LANES],
  input  logic [LANES-1:0][SEQ_W-1:0]   seq_i,
  input  logic [LANES-1:0][PC_W-1:0]    pc_i,
  input  logic [LANES-1:0][PC_W-1:0]    npc_i,
  input  logic [LANES-1:0]              taken_i,
  input  logic [LANES-1:0]              ptaken_i,
  output logic                          fire_o,
  output cause_e                        cause_o,
  output logic [SEQ_W-1:0]              seq_o,
  output logic [PC_W-1:0]               pc_o,
  output logic [PC_W-1:0]               npc_o,
  output logic                          taken_o,
  output logic                          ptaken_o,
  output logic [LANES-1:0]              win_o
);

  // First-wins lock: lanes are scanned oldest first; the lock is a
  // combinational variable, so it is free again every cycle.
  always_comb begin
    logic lock;
    lock     = 1'b0;
    win_o    = '0;
    cause_o  = CAUSE_NONE;
    seq_o    = '0;
    pc_o     = '0;
    npc_o    = '0;
    taken_o  = 1'b0;
    ptaken_o = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (!lock && cause_i[l] != CAUSE_NONE) begin
        lock     = 1'b1;
        win_o[l] = 1'b1;
        cause_o  = cause_i[l];
        seq_o    = seq_i[l];
        pc_o     = pc_i[l];
        npc_o    = npc_i[l];
        taken_o  = taken_i[l];
        ptaken_o = ptaken_i[l];
      end
    end
    fire_o = lock;
  end

endmodule

// File: rtl/redir_out_reg.sv
module redir_out_reg
  import redir_pkg::*;
#(
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  cause_e           cause_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  npc_i,
  input  logic             taken_i,
  input  logic             ptaken_i,
  output logic             valid_o,
  output logic             mispred_o,
  output logic             taken_o,
  output logic             incl_o,
  output logic             mark_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [PC_W-1:0]  target_o,
  output logic [PC_W-1:0]  bad_pc_o,
  output logic [CNT_W-1:0] cnt_pt_o,
  output logic [CNT_W-1:0] cnt_pnt_o
);

  // Restart point: a blocked load replays itself, others resume after
  function automatic logic [PC_W-1:0] restart_pc(input cause_e c,
                                                 input logic [PC_W-1:0] pc,
                                                 input logic [PC_W-1:0] npc);
    return (c == CAUSE_LDBLK) ? pc : npc;
  endfunction

  logic is_br, is_blk;
  assign is_br  = fire_i && (cause_i == CAUSE_BRANCH);
  assign is_blk = fire_i && (cause_i == CAUSE_LDBLK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o   <= 1'b0;
      mispred_o <= 1'b0;
      taken_o   <= 1'b0;
      incl_o    <= 1'b0;
      mark_o    <= 1'b0;
      seq_o     <= '0;
      target_o  <= '0;
      bad_pc_o  <= '0;
      cnt_pt_o  <= '0;
      cnt_pnt_o <= '0;
    end else begin
      valid_o   <= fire_i;
      mispred_o <= is_br;
      taken_o   <= is_br && taken_i;
      incl_o    <= is_blk;
      mark_o    <= is_blk;
      seq_o     <= fire_i ? seq_i : '0;
      target_o  <= fire_i ? restart_pc(cause_i, pc_i, npc_i) : '0;
      bad_pc_o  <= is_br ? pc_i : '0;
      if (is_br && ptaken_i)  cnt_pt_o  <= cnt_pt_o + 1'b1;
      if (is_br && !ptaken_i) cnt_pnt_o <= cnt_pnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/redirect_arbiter.sv
module redirect_arbiter
  import redir_pkg::*;
#(
  parameter int NT         = 2,
  parameter int LANES      = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16,
  localparam int TID_W     = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             ex_valid,
  input  logic [LANES-1:0]             ex_squashed,
  input  logic [LANES-1:0]             ex_mispred,
  input  logic [LANES-1:0]             ex_pred_taken,
  input  logic [LANES-1:0][TID_W-1:0]  ex_tid,
  input  logic [LANES-1:0][SEQ_W-1:0]  ex_seq,
  input  logic [LANES-1:0][PC_W-1:0]   ex_pc,
  input  logic [LANES-1:0][PC_W-1:0]   ex_npc,
  input  logic [NT-1:0]                mo_viol,
  input  logic [NT-1:0]                ld_blocked,
  input  logic [NT-1:0]                ld_handled,
  output logic [NT-1:0]                rd_valid,
  output logic [NT-1:0]                rd_mispred,
  output logic [NT-1:0]                rd_taken,
  output logic [NT-1:0]                rd_incl,
  output logic [NT-1:0]                ld_mark,
  output logic [NT-1:0][SEQ_W-1:0]     rd_seq,
  output logic [NT-1:0][PC_W-1:0]      rd_target,
  output logic [NT-1:0][PC_W-1:0]      rd_bad_pc,
  output logic [NT-1:0][CNT_W-1:0]     cnt_pt_wrong,
  output logic [NT-1:0][CNT_W-1:0]     cnt_pnt_wrong
);

  // Internal events, named for the checker
  cause_e               lane_cause [LANES][NT];
  cause_e               thr_lane_cause [NT][LANES];
  logic [LANES-1:0]     lane_taken;
  logic [NT-1:0]        thr_fire;
  cause_e               thr_cause [NT];
  logic [LANES-1:0]     thr_win [NT];
  logic [PC_W-1:0]      thr_pc [NT];
  logic [PC_W-1:0]      thr_npc [NT];
  logic [SEQ_W-1:0]     thr_seq [NT];
  logic [NT-1:0]        thr_taken;
  logic [NT-1:0]        thr_ptaken;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    redir_lane_eval #(
      .NT(NT), .TID_W(TID_W), .PC_W(PC_W), .INST_BYTES(INST_BYTES)
    ) u_eval (
      .valid_i   (ex_valid[l]),
      .squashed_i(ex_squashed[l]),
      .mispred_i (ex_mispred[l]),
      .tid_i     (ex_tid[l]),
      .pc_i      (ex_pc[l]),
      .npc_i     (ex_npc[l]),
      .viol_i    (mo_viol),
      .blk_i     (ld_blocked),
      .hnd_i     (ld_handled),
      .cause_o   (lane_cause[l]),
      .taken_o   (lane_taken[l])
    );
  end

  for (genvar t = 0; t < NT; t++) begin : g_thr
    for (genvar l = 0; l < LANES; l++) begin : g_x
      assign thr_lane_cause[t][l] = lane_cause[l][t];
    end

    redir_thread_pick #(
      .LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W)
    ) u_pick (
      .cause_i (thr_lane_cause[t]),
      .seq_i   (ex_seq),
      .pc_i    (ex_pc),
      .npc_i   (ex_npc),
      .taken_i (lane_taken),
      .ptaken_i(ex_pred_taken),
      .fire_o  (thr_fire[t]),
      .cause_o (thr_cause[t]),
      .seq_o   (thr_seq[t]),
      .pc_o    (thr_pc[t]),
      .npc_o   (thr_npc[t]),
      .taken_o (thr_taken[t]),
      .ptaken_o(thr_ptaken[t]),
      .win_o   (thr_win[t])
    );

    redir_out_reg #(
      .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)
    ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire_i   (thr_fire[t]),
      .cause_i  (thr_cause[t]),
      .seq_i    (thr_seq[t]),
      .pc_i     (thr_pc[t]),
      .npc_i    (thr_npc[t]),
      .taken_i  (thr_taken[t]),
      .ptaken_i (thr_ptaken[t]),
      .valid_o  (rd_valid[t]),
      .mispred_o(rd_mispred[t]),
      .taken_o  (rd_taken[t]),
      .incl_o   (rd_incl[t]),
      .mark_o   (ld_mark[t]),
      .seq_o    (rd_seq[t]),
      .target_o (rd_target[t]),
      .bad_pc_o (rd_bad_pc[t]),
      .cnt_pt_o (cnt_pt_wrong[t]),
      .cnt_pnt_o(cnt_pnt_wrong[t])
    );
  end

endmodule

// File: rtl/redirect_arbiter_chk.sv
module redirect_arbiter_chk
  import redir_pkg::*;
#(
  parameter int NT    = 2,
  parameter int LANES = 4,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int CNT_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NT-1:0]            ld_handled,
  input logic [NT-1:0]            rd_valid,
  input logic [NT-1:0]            rd_mispred,
  input logic [NT-1:0]            rd_taken,
  input logic [NT-1:0]            rd_incl,
  input logic [NT-1:0]            ld_mark,
  input logic [NT-1:0][PC_W-1:0]  rd_target,
  input logic [NT-1:0][PC_W-1:0]  rd_bad_pc,
  input logic [NT-1:0][CNT_W-1:0] cnt_pt_wrong,
  input logic [NT-1:0][CNT_W-1:0] cnt_pnt_wrong,
  input logic [NT-1:0]            thr_fire,
  input cause_e                   thr_cause [NT],
  input logic [LANES-1:0]         thr_win [NT],
  input logic [PC_W-1:0]          thr_pc [NT]
);

  for (genvar t = 0; t < NT; t++) begin : g_a
    p_one_win_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(thr_win[t]));

    p_fire_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      thr_fire[t] |=> rd_valid[t]);

    p_quiet_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_fire[t] |=> !rd_valid[t]);

    p_br_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[t] && rd_mispred[t] |-> !rd_incl[t]);

    p_nonbr_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[t] && !rd_mispred[t] |-> !rd_taken[t] && (rd_bad_pc[t] == '0));

    p_blk_self_r7: assert property (@(posedge clk) disable iff (!rst_n)
      thr_fire[t] && (thr_cause[t] == CAUSE_LDBLK)
        |=> rd_incl[t] && ld_mark[t] && (rd_target[t] == $past(thr_pc[t])));

    p_handled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_handled[t] |=> !ld_mark[t]);

    p_mark_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_mark[t] |-> rd_valid[t] && rd_incl[t]);

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[t] && rd_mispred[t]
        |-> (cnt_pt_wrong[t] != $past(cnt_pt_wrong[t])) !=
            (cnt_pnt_wrong[t] != $past(cnt_pnt_wrong[t])));

    p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid[t] && rd_mispred[t])
        |-> $stable(cnt_pt_wrong[t]) && $stable(cnt_pnt_wrong[t]));
  end

endmodule

bind redirect_arbiter redirect_arbiter_chk #(
  .NT(NT), .LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/redirect_arbiter_bench.sv
module redirect_arbiter_bench;
  localparam int NT = 2, LANES = 4, SEQ_W = 16, PC_W = 32, CNT_W = 16;
  localparam int TID_W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [LANES-1:0]            ex_valid, ex_squashed, ex_mispred, ex_pred_taken;
  logic [LANES-1:0][TID_W-1:0] ex_tid;
  logic [LANES-1:0][SEQ_W-1:0] ex_seq;
  logic [LANES-1:0][PC_W-1:0]  ex_pc, ex_npc;
  logic [NT-1:0]               mo_viol, ld_blocked, ld_handled;
  logic [NT-1:0]               rd_valid, rd_mispred, rd_taken, rd_incl, ld_mark;
  logic [NT-1:0][SEQ_W-1:0]    rd_seq;
  logic [NT-1:0][PC_W-1:0]     rd_target, rd_bad_pc;
  logic [NT-1:0][CNT_W-1:0]    cnt_pt_wrong, cnt_pnt_wrong;

  redirect_arbiter #(.NT(NT), .LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W),
                     .INST_BYTES(4), .CNT_W(CNT_W)) u_redirect_arbiter (.*);

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [NT-1:0] hnd_m;
  logic [NT-1:0][CNT_W-1:0] m_pt, m_pnt;
  logic [15:0] seqc = 16'd1;

  function automatic logic exp_taken(input logic [31:0] pc, input logic [31:0] npc);
    return (pc + 32'd4) != npc;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    ex_valid = '0; ex_squashed = '0; ex_mispred = '0; ex_pred_taken = '0;
    ex_tid = '0; ex_seq = '0; ex_pc = '0; ex_npc = '0;
    mo_viol = '0; ld_blocked = '0;
  endtask

  task automatic put(input int l, input int t, input logic [31:0] pc,
                     input logic [31:0] npc, input bit mis, input bit ptk);
    ex_valid[l] = 1'b1; ex_tid[l] = TID_W'(t); ex_seq[l] = seqc; seqc++;
    ex_pc[l] = pc; ex_npc[l] = npc; ex_mispred[l] = mis; ex_pred_taken[l] = ptk;
  endtask

  // Apply current inputs, wait one edge, compare with the model
  task automatic step(input string tag);
    bit ev [NT]; bit em [NT]; bit et [NT]; bit ei [NT];
    logic [15:0] es [NT]; logic [31:0] etg [NT]; logic [31:0] eb [NT];
    for (int t = 0; t < NT; t++) begin
      if (!ld_blocked[t]) hnd_m[t] = 1'b0;
    end
    ld_handled = hnd_m & ld_blocked;
    for (int t = 0; t < NT; t++) begin
      ev[t] = 0; em[t] = 0; et[t] = 0; ei[t] = 0; es[t] = 0; etg[t] = 0; eb[t] = 0;
      for (int l = 0; l < LANES; l++) begin
        if (!ev[t] && ex_valid[l] && !ex_squashed[l] && int'(ex_tid[l]) == t) begin
          if (ex_mispred[l]) begin
            ev[t] = 1; em[t] = 1; es[t] = ex_seq[l]; etg[t] = ex_npc[l];
            eb[t] = ex_pc[l]; et[t] = exp_taken(ex_pc[l], ex_npc[l]);
            if (ex_pred_taken[l]) m_pt[t]++; else m_pnt[t]++;
          end else if (mo_viol[t]) begin
            ev[t] = 1; es[t] = ex_seq[l]; etg[t] = ex_npc[l];
          end else if (ld_blocked[t] && !ld_handled[t]) begin
            ev[t] = 1; ei[t] = 1; es[t] = ex_seq[l]; etg[t] = ex_pc[l];
          end
        end
      end
    end
    @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      chk(rd_valid[t] == ev[t], {tag, " R10/R2 valid"}, 64'(rd_valid[t]), 64'(ev[t]));
      chk(ld_mark[t] == ei[t], {tag, " R7 mark"}, 64'(ld_mark[t]), 64'(ei[t]));
      chk(cnt_pt_wrong[t] == m_pt[t], {tag, " R9 pt"}, 64'(cnt_pt_wrong[t]), 64'(m_pt[t]));
      chk(cnt_pnt_wrong[t] == m_pnt[t], {tag, " R9 pnt"}, 64'(cnt_pnt_wrong[t]), 64'(m_pnt[t]));
      if (ev[t]) begin
        chk(rd_seq[t] == es[t], {tag, " R2/R4 seq"}, 64'(rd_seq[t]), 64'(es[t]));
        chk(rd_target[t] == etg[t], {tag, " R4/R6/R7 target"}, 64'(rd_target[t]), 64'(etg[t]));
        chk(rd_mispred[t] == em[t], {tag, " R3 mispred"}, 64'(rd_mispred[t]), 64'(em[t]));
        chk(rd_taken[t] == et[t], {tag, " R5 taken"}, 64'(rd_taken[t]), 64'(et[t]));
        chk(rd_incl[t] == ei[t], {tag, " R7 incl"}, 64'(rd_incl[t]), 64'(ei[t]));
        chk(rd_bad_pc[t] == eb[t], {tag, " R4/R6 badpc"}, 64'(rd_bad_pc[t]), 64'(eb[t]));
      end
      if (ei[t]) hnd_m[t] = 1'b1;
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    hnd_m = '0; m_pt = '0; m_pnt = '0; ld_handled = '0;
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(rd_valid == '0, "R1 valid", 64'(rd_valid), 0);
    chk(ld_mark == '0, "R1 mark", 64'(ld_mark), 0);
    chk(cnt_pt_wrong == '0 && cnt_pnt_wrong == '0, "R1 counters",
        64'(cnt_pt_wrong), 0);

    // R11/R4/R5/R6: both threads in one cycle
    clr(); put(0, 0, 32'h100, 32'h200, 1, 1); put(1, 1, 32'h300, 32'h304, 0, 0);
    mo_viol[1] = 1'b1; step("D1 R11");
    // R2: violation on older lane wins over younger mispredict
    clr(); put(0, 0, 32'h400, 32'h404, 0, 0); put(1, 0, 32'h404, 32'h900, 1, 0);
    mo_viol[0] = 1'b1; step("D2 R2");
    // R3/R5: mispredict outranks violation; sequential next PC
    clr(); put(0, 0, 32'h500, 32'h504, 1, 1); mo_viol[0] = 1'b1; ld_blocked[0] = 1'b1;
    step("D3 R3");
    // R8: squashed, invalid and other-thread lanes ignored for thread 0
    clr(); put(0, 0, 32'h600, 32'h700, 1, 0); ex_squashed[0] = 1'b1;
    put(1, 1, 32'h610, 32'h614, 0, 0); put(2, 0, 32'h620, 32'h800, 1, 0);
    ex_valid[2] = 1'b0; step("D4 R8");
    // R7: blocked load fires once while held
    for (int k = 0; k < 3; k++) begin
      clr(); put(0, 0, 32'h1000, 32'h1004, 0, 0); ld_blocked[0] = 1'b1;
      step("D5 R7");
    end
    // R10: idle cycle drops valid
    clr(); step("D6 R10");

    for (int n = 0; n < 600; n++) begin
      clr();
      for (int l = 0; l < LANES; l++) begin
        if ($urandom_range(3) != 0) begin
          logic [31:0] pc;
          pc = {$urandom_range(32'h3fff_ffff), 2'b00};
          put(l, int'($urandom_range(NT - 1)), pc,
              ($urandom_range(1) == 0) ? pc + 32'd4 : {$urandom_range(32'h3fff_ffff), 2'b00},
              $urandom_range(4) == 0, $urandom_range(1) == 1);
          ex_squashed[l] = ($urandom_range(9) == 0);
        end
      end
      for (int t = 0; t < NT; t++) begin
        mo_viol[t] = ($urandom_range(9) == 0);
        ld_blocked[t] = ($urandom_range(5) < 2);
      end
      step("RND");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule